// File: doc/BRIEF.md
# Last-Arrive Edge Classifier

This block sits beside the reorder buffer of an out-of-order core. It watches per-instruction pipeline events, each tagged with the reorder-buffer slot it concerns. For every retiring instruction it names the one dependence that arrived last at each of the instruction's three nodes: fetch (F), execute (E) and commit (C). It does not time any edge. It picks the edge with a fixed rule per node kind, using only the order in which events were seen.

Each retirement yields one record. The record holds the slot of the retiring instruction and, for each of the three nodes, an edge kind and a producer identity. The producer identity is a 2-bit node tag followed by the producer's slot. Records leave in commit order, at most one per cycle, through a valid/ready handshake. Retirement is held off while an unaccepted record is waiting. A pipeline flush drops all per-slot knowledge, so squashed instructions never produce a record.

Edge kind codes are NONE=0, F-to-F=1, E-to-F=2, C-to-F=3, F-to-E=4, E-to-E=5, E-to-C=6 and C-to-C=7. Node tags are F=1, E=2 and C=3. The producer field is {tag, slot}, and it is all zero for NONE.

Top module: `le_classifier`

## Requirements
- R1: After reset `rec_vld` is 0 and `retire_rdy` is 1.
- R2: The first fetch accepted in a cycle after `misp_vld` carries an E-to-F edge (2) with producer {E, misp_slot} from the latest mispredict. The mispredict takes priority over a pending reorder-buffer stall, and both pending marks clear on that fetch.
- R3: With no mispredict pending, the first fetch after `stall_vld` carries a C-to-F edge (3) whose producer is {C, slot of the most recently retired instruction}, with slot 0 if nothing has retired.
- R4: Any other fetch carries an F-to-F edge (1) with producer {F, slot of the previous accepted fetch}. It carries NONE if no fetch has been accepted since reset or the last flush.
- R5: An instruction for which no operand became ready after fetch gets an F-to-E edge (4) with producer {F, own slot}.
- R6: Otherwise the E edge is E-to-E (5). Its producer is {E, producer slot of the operand that woke last}. Operand i's producer slot sits at bits [i*SW +: SW] of `fetch_src_prod`. On a same-cycle tie the higher-numbered operand wins, and wakes of operands already ready are ignored.
- R7: The C edge is E-to-C (6) with producer {E, own slot} when the commit pointer reached the slot before any earlier-cycle issue of it. If no pointer event was seen, it is E-to-C when the slot was never issued.
- R8: Otherwise the C edge is C-to-C (7) with producer {C, previously retired slot}, or NONE for the first retirement since reset.
- R9: `retire_rdy` = (!rec_vld or rec_rdy) and not flush. An accepted retirement of an occupied slot presents its record on the next cycle. A record is held unchanged while `rec_vld` is high and `rec_rdy` is low.
- R10: A flush empties every slot, clears the pending mispredict/stall marks and the previous-fetch memory, and ignores any fetch in the same cycle. A mispredict strobed in the flush cycle is still kept. A later retirement of a squashed slot yields no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Pipeline flush |
| fetch_vld | input | 1 | An instruction was fetched into a slot |
| fetch_slot | input | SW | Slot of the fetched instruction |
| fetch_src_rdy | input | NSRC | Per-operand ready-at-fetch bits |
| fetch_src_prod | input | NSRC*SW | Per-operand producer slots |
| misp_vld | input | 1 | A branch resolved as mispredicted |
| misp_slot | input | SW | Slot of that branch |
| stall_vld | input | 1 | Fetch was held by a full reorder buffer |
| wake_vld | input | 1 | Operands of a slot became ready |
| wake_slot | input | SW | Slot being woken |
| wake_mask | input | NSRC | Operands becoming ready this cycle |
| issue_vld | input | 1 | A slot finished execution |
| issue_slot | input | SW | Slot that finished |
| head_vld | input | 1 | The commit pointer reached a slot |
| head_slot | input | SW | Slot reached |
| retire_vld | input | 1 | A slot retires |
| retire_slot | input | SW | Retiring slot |
| retire_rdy | output | 1 | Retirement can be accepted |
| rec_vld | output | 1 | Record valid |
| rec_rdy | input | 1 | Consumer accepts the record |
| rec_slot | output | SW | Slot of the retired instruction |
| rec_f_type | output | 3 | Edge kind into the F node |
| rec_f_prod | output | SW+2 | Producer {tag, slot} of the F edge |
| rec_e_type | output | 3 | Edge kind into the E node |
| rec_e_prod | output | SW+2 | Producer of the E edge |
| rec_c_type | output | 3 | Edge kind into the C node |
| rec_c_prod | output | SW+2 | Producer of the C edge |

## Verification
Bad per-slot state shows up only when that slot retires: a stale wake index or a lost issue bit appears as a wrong E or C field in the record one cycle after the retirement is accepted. Bad fetch-side state shows up in the F field of the record of the next fetched instruction, which may be many cycles later. A record consumer that compares every field on every retirement therefore sees each fault within one retirement of the damaged instruction. Flush faults appear as records for slots that should have been empty.

// File: rtl/le_pkg.sv
// Shared encodings for the last-arrive edge classifier.
// Edge kinds and node tags are part of the record format at the ports.
package le_pkg;
    typedef enum logic [2:0] {
        EDGE_NONE = 3'd0,
        EDGE_FF   = 3'd1,
        EDGE_EF   = 3'd2,
        EDGE_CF   = 3'd3,
        EDGE_FE   = 3'd4,
        EDGE_EE   = 3'd5,
        EDGE_EC   = 3'd6,
        EDGE_CC   = 3'd7
    } edge_kind_e;

    localparam logic [1:0] NODE_NONE = 2'd0;
    localparam logic [1:0] NODE_F    = 2'd1;
    localparam logic [1:0] NODE_E    = 2'd2;
    localparam logic [1:0] NODE_C    = 2'd3;
endpackage

// File: rtl/le_fetch_edge.sv
// Fetch-side edge decision.
// Remembers a pending mispredict redirect, a pending reorder-buffer stall and
// the previous fetched slot, and classifies each new fetch from them.
// Assumes event strobes affect only fetches in later cycles.
module le_fetch_edge
    import le_pkg::*;
#(
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          fetch_vld,
    input  logic [SW-1:0] fetch_slot,
    input  logic          misp_vld,
    input  logic [SW-1:0] misp_slot,
    input  logic          stall_vld,
    input  logic [SW-1:0] last_ret_slot,
    output edge_kind_e    f_kind,
    output logic [SW+1:0] f_prod
);
    logic          misp_pend_q;
    logic [SW-1:0] misp_slot_q;
    logic          stall_pend_q;
    logic          prev_vld_q;
    logic [SW-1:0] prev_slot_q;
    logic          fetch_go;

    assign fetch_go = fetch_vld & ~flush;

    // Pick the last-arriving edge into the F node of a fetch this cycle.
    always_comb begin
        if (misp_pend_q) begin
            f_kind = EDGE_EF;
            f_prod = {NODE_E, misp_slot_q};
        end else if (stall_pend_q) begin
            f_kind = EDGE_CF;
            f_prod = {NODE_C, last_ret_slot};
        end else if (prev_vld_q) begin
            f_kind = EDGE_FF;
            f_prod = {NODE_F, prev_slot_q};
        end else begin
            f_kind = EDGE_NONE;
            f_prod = '0;
        end
    end

    // Track pending redirect, pending stall and the previous fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            misp_pend_q  <= 1'b0;
            misp_slot_q  <= '0;
            stall_pend_q <= 1'b0;
            prev_vld_q   <= 1'b0;
            prev_slot_q  <= '0;
        end else begin
            if (misp_vld) begin
                misp_pend_q <= 1'b1;
                misp_slot_q <= misp_slot;
            end else if (flush || fetch_go) begin
                misp_pend_q <= 1'b0;
            end
            if (flush) begin
                stall_pend_q <= 1'b0;
            end else if (stall_vld) begin
                stall_pend_q <= 1'b1;
            end else if (fetch_go) begin
                stall_pend_q <= 1'b0;
            end
            if (flush) begin
                prev_vld_q <= 1'b0;
            end else if (fetch_go) begin
                prev_vld_q  <= 1'b1;
                prev_slot_q <= fetch_slot;
            end
        end
    end
endmodule

// File: rtl/le_slot_table.sv
// Per-slot tracking of operand arrival order, issue and commit-pointer arrival.
// One state entry per reorder-buffer slot; the retiring slot is read out and
// its E edge and commit-lateness flag are resolved combinationally.
// Assumes DEPTH equals 2**SW. A fetch into a slot overrides other events to it.
module le_slot_table
    import le_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NSRC  = 2,
    parameter int SW    = 4,
    parameter int IW    = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               fetch_vld,
    input  logic [SW-1:0]      fetch_slot,
    input  logic [NSRC-1:0]    fetch_rdy,
    input  logic [NSRC*SW-1:0] fetch_prod,
    input  edge_kind_e         f_kind,
    input  logic [SW+1:0]      f_prod,
    input  logic               wake_vld,
    input  logic [SW-1:0]      wake_slot,
    input  logic [NSRC-1:0]    wake_mask,
    input  logic               issue_vld,
    input  logic [SW-1:0]      issue_slot,
    input  logic               head_vld,
    input  logic [SW-1:0]      head_slot,
    input  logic               ret_take,
    input  logic [SW-1:0]      ret_slot,
    output logic               ret_occ,
    output edge_kind_e         ret_f_kind,
    output logic [SW+1:0]      ret_f_prod,
    output edge_kind_e         ret_e_kind,
    output logic [SW+1:0]      ret_e_prod,
    output logic               ret_c_late
);
    logic            occ_q    [DEPTH];
    edge_kind_e      fkind_q  [DEPTH];
    logic [SW+1:0]   fprod_q  [DEPTH];
    logic [NSRC-1:0] pend_q   [DEPTH];
    logic [SW-1:0]   sprod_q  [DEPTH][NSRC];
    logic            woke_q   [DEPTH];
    logic [IW-1:0]   last_q   [DEPTH];
    logic            issued_q [DEPTH];
    logic            head_q   [DEPTH];
    logic            late_q   [DEPTH];

    // Index of the highest set bit; ties go to the higher operand.
    function automatic logic [IW-1:0] top_bit(input logic [NSRC-1:0] v);
        logic [IW-1:0] r;
        r = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (v[i]) r = IW'(i);
        end
        return r;
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic            fetch_hit;
        logic            wake_hit;
        logic            issue_hit;
        logic            head_hit;
        logic            ret_hit;
        logic [NSRC-1:0] newly;

        assign fetch_hit = fetch_vld && (fetch_slot == SW'(g));
        assign wake_hit  = wake_vld  && (wake_slot  == SW'(g));
        assign issue_hit = issue_vld && (issue_slot == SW'(g));
        assign head_hit  = head_vld  && (head_slot  == SW'(g));
        assign ret_hit   = ret_take  && (ret_slot   == SW'(g));
        assign newly     = wake_mask & pend_q[g];

        // Update the state of one slot from the events that target it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ_q[g]    <= 1'b0;
                fkind_q[g]  <= EDGE_NONE;
                fprod_q[g]  <= '0;
                pend_q[g]   <= '0;
                woke_q[g]   <= 1'b0;
                last_q[g]   <= '0;
                issued_q[g] <= 1'b0;
                head_q[g]   <= 1'b0;
                late_q[g]   <= 1'b0;
                for (int i = 0; i < NSRC; i++) sprod_q[g][i] <= '0;
            end else if (flush) begin
                occ_q[g] <= 1'b0;
            end else if (fetch_hit) begin
                occ_q[g]    <= 1'b1;
                fkind_q[g]  <= f_kind;
                fprod_q[g]  <= f_prod;
                pend_q[g]   <= ~fetch_rdy;
                woke_q[g]   <= 1'b0;
                last_q[g]   <= '0;
                issued_q[g] <= 1'b0;
                head_q[g]   <= 1'b0;
                late_q[g]   <= 1'b0;
                for (int i = 0; i < NSRC; i++) sprod_q[g][i] <= fetch_prod[i*SW +: SW];
            end else if (occ_q[g]) begin
                if (wake_hit && (newly != '0)) begin
                    pend_q[g] <= pend_q[g] & ~wake_mask;
                    woke_q[g] <= 1'b1;
                    last_q[g] <= top_bit(newly);
                end
                if (issue_hit) issued_q[g] <= 1'b1;
                if (head_hit) begin
                    head_q[g] <= 1'b1;
                    late_q[g] <= ~issued_q[g];
                end
                if (ret_hit) occ_q[g] <= 1'b0;
            end
        end
    end

    // Read out and resolve the retiring slot.
    always_comb begin
        ret_occ    = occ_q[ret_slot];
        ret_f_kind = fkind_q[ret_slot];
        ret_f_prod = fprod_q[ret_slot];
        if (woke_q[ret_slot]) begin
            ret_e_kind = EDGE_EE;
            ret_e_prod = {NODE_E, sprod_q[ret_slot][last_q[ret_slot]]};
        end else begin
            ret_e_kind = EDGE_FE;
            ret_e_prod = {NODE_F, ret_slot};
        end
        ret_c_late = head_q[ret_slot] ? late_q[ret_slot] : ~issued_q[ret_slot];
    end
endmodule

// File: rtl/le_record_out.sv
// Output record register with valid/ready handshake.
// Also keeps the previously retired slot, which resolves C-to-C edges and
// feeds C-to-F edges on the fetch side. Assumes take only when not stalled.
module le_record_out
    import le_pkg::*;
#(
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [SW-1:0] ret_slot,
    input  edge_kind_e    f_kind,
    input  logic [SW+1:0] f_prod,
    input  edge_kind_e    e_kind,
    input  logic [SW+1:0] e_prod,
    input  logic          c_late,
    input  logic          rec_rdy,
    output logic          rec_vld,
    output logic [SW-1:0] rec_slot,
    output edge_kind_e    rec_f_kind,
    output logic [SW+1:0] rec_f_prod,
    output edge_kind_e    rec_e_kind,
    output logic [SW+1:0] rec_e_prod,
    output edge_kind_e    rec_c_kind,
    output logic [SW+1:0] rec_c_prod,
    output logic [SW-1:0] last_ret_slot
);
    logic          prev_vld_q;
    logic [SW-1:0] prev_slot_q;
    edge_kind_e    c_kind;
    logic [SW+1:0] c_prod;

    assign last_ret_slot = prev_slot_q;

    // Pick the last-arriving edge into the C node of the retiring instruction.
    always_comb begin
        if (c_late) begin
            c_kind = EDGE_EC;
            c_prod = {NODE_E, ret_slot};
        end else if (prev_vld_q) begin
            c_kind = EDGE_CC;
            c_prod = {NODE_C, prev_slot_q};
        end else begin
            c_kind = EDGE_NONE;
            c_prod = '0;
        end
    end

    // Load a record on retirement, drop it once consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_vld     <= 1'b0;
            rec_slot    <= '0;
            rec_f_kind  <= EDGE_NONE;
            rec_f_prod  <= '0;
            rec_e_kind  <= EDGE_NONE;
            rec_e_prod  <= '0;
            rec_c_kind  <= EDGE_NONE;
            rec_c_prod  <= '0;
            prev_vld_q  <= 1'b0;
            prev_slot_q <= '0;
        end else if (take) begin
            rec_vld     <= 1'b1;
            rec_slot    <= ret_slot;
            rec_f_kind  <= f_kind;
            rec_f_prod  <= f_prod;
            rec_e_kind  <= e_kind;
            rec_e_prod  <= e_prod;
            rec_c_kind  <= c_kind;
            rec_c_prod  <= c_prod;
            prev_vld_q  <= 1'b1;
            prev_slot_q <= ret_slot;
        end else if (rec_rdy) begin
            rec_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/le_classifier.sv
// Top of the last-arrive edge classifier.
// Joins the fetch-side decision, the per-slot table and the record register,
// and gates retirement on record backpressure and flush.
// Assumes ROB_DEPTH is a power of two.
module le_classifier
    import le_pkg::*;
#(
    parameter int ROB_DEPTH = 16,
    parameter int NSRC      = 2,
    localparam int SW       = $clog2(ROB_DEPTH),
    localparam int PW       = SW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               fetch_vld,
    input  logic [SW-1:0]      fetch_slot,
    input  logic [NSRC-1:0]    fetch_src_rdy,
    input  logic [NSRC*SW-1:0] fetch_src_prod,
    input  logic               misp_vld,
    input  logic [SW-1:0]      misp_slot,
    input  logic               stall_vld,
    input  logic               wake_vld,
    input  logic [SW-1:0]      wake_slot,
    input  logic [NSRC-1:0]    wake_mask,
    input  logic               issue_vld,
    input  logic [SW-1:0]      issue_slot,
    input  logic               head_vld,
    input  logic [SW-1:0]      head_slot,
    input  logic               retire_vld,
    input  logic [SW-1:0]      retire_slot,
    output logic               retire_rdy,
    output logic               rec_vld,
    input  logic               rec_rdy,
    output logic [SW-1:0]      rec_slot,
    output logic [2:0]         rec_f_type,
    output logic [PW-1:0]      rec_f_prod,
    output logic [2:0]         rec_e_type,
    output logic [PW-1:0]      rec_e_prod,
    output logic [2:0]         rec_c_type,
    output logic [PW-1:0]      rec_c_prod
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    edge_kind_e    new_f_kind;
    logic [PW-1:0] new_f_prod;
    logic [SW-1:0] last_ret_slot;
    logic          ret_occ;
    edge_kind_e    ret_f_kind;
    logic [PW-1:0] ret_f_prod;
    edge_kind_e    ret_e_kind;
    logic [PW-1:0] ret_e_prod;
    logic          ret_c_late;
    logic          take;
    edge_kind_e    out_f_kind;
    edge_kind_e    out_e_kind;
    edge_kind_e    out_c_kind;

    assign retire_rdy = (~rec_vld | rec_rdy) & ~flush;
    assign take       = retire_vld & retire_rdy & ret_occ;
    assign rec_f_type = out_f_kind;
    assign rec_e_type = out_e_kind;
    assign rec_c_type = out_c_kind;

    le_fetch_edge #(.SW(SW)) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (flush),
        .fetch_vld     (fetch_vld),
        .fetch_slot    (fetch_slot),
        .misp_vld      (misp_vld),
        .misp_slot     (misp_slot),
        .stall_vld     (stall_vld),
        .last_ret_slot (last_ret_slot),
        .f_kind        (new_f_kind),
        .f_prod        (new_f_prod)
    );

    le_slot_table #(.DEPTH(ROB_DEPTH), .NSRC(NSRC), .SW(SW), .IW(IW)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .fetch_vld  (fetch_vld),
        .fetch_slot (fetch_slot),
        .fetch_rdy  (fetch_src_rdy),
        .fetch_prod (fetch_src_prod),
        .f_kind     (new_f_kind),
        .f_prod     (new_f_prod),
        .wake_vld   (wake_vld),
        .wake_slot  (wake_slot),
        .wake_mask  (wake_mask),
        .issue_vld  (issue_vld),
        .issue_slot (issue_slot),
        .head_vld   (head_vld),
        .head_slot  (head_slot),
        .ret_take   (take),
        .ret_slot   (retire_slot),
        .ret_occ    (ret_occ),
        .ret_f_kind (ret_f_kind),
        .ret_f_prod (ret_f_prod),
        .ret_e_kind (ret_e_kind),
        .ret_e_prod (ret_e_prod),
        .ret_c_late (ret_c_late)
    );

    le_record_out #(.SW(SW)) u_rec (
        .clk           (clk),
        .rst_n         (rst_n),
        .take          (take),
        .ret_slot      (retire_slot),
        .f_kind        (ret_f_kind),
        .f_prod        (ret_f_prod),
        .e_kind        (ret_e_kind),
        .e_prod        (ret_e_prod),
        .c_late        (ret_c_late),
        .rec_rdy       (rec_rdy),
        .rec_vld       (rec_vld),
        .rec_slot      (rec_slot),
        .rec_f_kind    (out_f_kind),
        .rec_f_prod    (rec_f_prod),
        .rec_e_kind    (out_e_kind),
        .rec_e_prod    (rec_e_prod),
        .rec_c_kind    (out_c_kind),
        .rec_c_prod    (rec_c_prod),
        .last_ret_slot (last_ret_slot)
    );
endmodule

// File: rtl/le_classifier_chk.sv
// Port-level checker for the last-arrive edge classifier, bound to the top.
// Assumes the record encoding given in the requirements.
module le_classifier_chk #(
    parameter int SW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          retire_vld,
    input logic [SW-1:0] retire_slot,
    input logic          retire_rdy,
    input logic          rec_vld,
    input logic          rec_rdy,
    input logic [SW-1:0] rec_slot,
    input logic [2:0]    rec_f_type,
    input logic [SW+1:0] rec_f_prod,
    input logic [2:0]    rec_e_type,
    input logic [SW+1:0] rec_e_prod,
    input logic [2:0]    rec_c_type,
    input logic [SW+1:0] rec_c_prod
);
    // R9
    hold_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_vld && !rec_rdy |=> rec_vld && $stable(rec_slot) && $stable(rec_f_type)
            && $stable(rec_f_prod) && $stable(rec_e_type) && $stable(rec_e_prod)
            && $stable(rec_c_type) && $stable(rec_c_prod));

    // R9
    new_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_vld) |-> $past(retire_vld) && $past(retire_rdy) && rec_slot == $past(retire_slot));

    // R10
    flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !retire_rdy);

    // R5
    fe_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_vld && rec_e_type == 3'd4 |-> rec_e_prod == {2'd1, rec_slot});

    // R7
    ec_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_vld && rec_c_type == 3'd6 |-> rec_c_prod == {2'd2, rec_slot});
endmodule

bind le_classifier le_classifier_chk #(.SW(SW)) u_le_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .retire_vld  (retire_vld),
    .retire_slot (retire_slot),
    .retire_rdy  (retire_rdy),
    .rec_vld     (rec_vld),
    .rec_rdy     (rec_rdy),
    .rec_slot    (rec_slot),
    .rec_f_type  (rec_f_type),
    .rec_f_prod  (rec_f_prod),
    .rec_e_type  (rec_e_type),
    .rec_e_prod  (rec_e_prod),
    .rec_c_type  (rec_c_type),
    .rec_c_prod  (rec_c_prod)
);

// File: tb/test_le_classifier.sv
// Bench: behavioural per-cycle reference model compared on every clock.
module test_le_classifier;
    localparam int D = 16;
    localparam int NS = 2;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 0, fetch_vld = 0, misp_vld = 0, stall_vld = 0, wake_vld = 0;
    logic issue_vld = 0, head_vld = 0, retire_vld = 0, rec_rdy = 1;
    logic [SW-1:0] fetch_slot = 0, misp_slot = 0, wake_slot = 0, issue_slot = 0;
    logic [SW-1:0] head_slot = 0, retire_slot = 0;
    logic [NS-1:0] fetch_src_rdy = 0, wake_mask = 0;
    logic [NS*SW-1:0] fetch_src_prod = 0;
    logic retire_rdy, rec_vld;
    logic [SW-1:0] rec_slot;
    logic [2:0] rec_f_type, rec_e_type, rec_c_type;
    logic [SW+1:0] rec_f_prod, rec_e_prod, rec_c_prod;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    le_classifier #(.ROB_DEPTH(D), .NSRC(NS)) i_le_classifier (.*);

    // reference model state
    bit m_occ [D];
    int m_fk [D];
    int m_fp [D];
    bit [1:0] m_pend [D];
    int m_sp [D][NS];
    bit m_woke [D];
    int m_last [D];
    bit m_iss [D];
    bit m_head [D];
    bit m_late [D];
    bit m_mp, m_stall, m_pfv, m_prv;
    int m_ms, m_pfs, m_prs;
    bit e_vld;
    int e_slot, e_fk, e_fp, e_ek, e_ep, e_ck, e_cp;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < D; s++) begin
                m_occ[s] = 0; m_woke[s] = 0; m_iss[s] = 0; m_head[s] = 0;
            end
            m_mp = 0; m_stall = 0; m_pfv = 0; m_prv = 0; m_ms = 0; m_pfs = 0; m_prs = 0;
            e_vld = 0;
        end else begin
            bit rdy, take, fgo;
            int fk, fp, rs, fs;
            rdy = (!e_vld || rec_rdy) && !flush;
            rs = int'(retire_slot);
            fs = int'(fetch_slot);
            take = retire_vld && rdy && m_occ[rs];
            fgo = fetch_vld && !flush;
            // fetch classification from old state
            if (m_mp) begin fk = 2; fp = 2*16 + m_ms; end
            else if (m_stall) begin fk = 3; fp = 3*16 + m_prs; end
            else if (m_pfv) begin fk = 1; fp = 1*16 + m_pfs; end
            else begin fk = 0; fp = 0; end
            // record
            if (take) begin
                bit late;
                e_vld = 1; e_slot = rs; e_fk = m_fk[rs]; e_fp = m_fp[rs];
                if (m_woke[rs]) begin e_ek = 5; e_ep = 2*16 + m_sp[rs][m_last[rs]]; end
                else begin e_ek = 4; e_ep = 1*16 + rs; end
                late = m_head[rs] ? m_late[rs] : !m_iss[rs];
                if (late) begin e_ck = 6; e_cp = 2*16 + rs; end
                else if (m_prv) begin e_ck = 7; e_cp = 3*16 + m_prs; end
                else begin e_ck = 0; e_cp = 0; end
            end else if (rec_rdy) e_vld = 0;
            // slots
            if (flush) begin
                for (int s = 0; s < D; s++) m_occ[s] = 0;
            end else begin
                int hs, is, ws;
                hs = int'(head_slot); is = int'(issue_slot); ws = int'(wake_slot);
                if (head_vld && m_occ[hs] && !(fetch_vld && fs == hs)) begin
                    m_head[hs] = 1; m_late[hs] = !m_iss[hs];
                end
                if (issue_vld && m_occ[is] && !(fetch_vld && fs == is)) m_iss[is] = 1;
                if (wake_vld && m_occ[ws] && !(fetch_vld && fs == ws)) begin
                    bit [1:0] nw;
                    nw = wake_mask & m_pend[ws];
                    if (nw != 0) begin
                        m_pend[ws] = m_pend[ws] & ~wake_mask;
                        m_woke[ws] = 1;
                        m_last[ws] = nw[1] ? 1 : 0;
                    end
                end
                if (take) m_occ[rs] = 0;
                if (fetch_vld) begin
                    m_occ[fs] = 1; m_fk[fs] = fk; m_fp[fs] = fp; m_pend[fs] = ~fetch_src_rdy;
                    m_woke[fs] = 0; m_last[fs] = 0; m_iss[fs] = 0; m_head[fs] = 0; m_late[fs] = 0;
                    for (int i = 0; i < NS; i++) m_sp[fs][i] = int'(fetch_src_prod[i*SW +: SW]);
                end
            end
            if (take) begin m_prv = 1; m_prs = rs; end
            // fetch-side pending marks
            if (misp_vld) begin m_mp = 1; m_ms = int'(misp_slot); end
            else if (flush || fgo) m_mp = 0;
            if (flush) m_stall = 0; else if (stall_vld) m_stall = 1; else if (fgo) m_stall = 0;
            if (flush) m_pfv = 0; else if (fgo) begin m_pfv = 1; m_pfs = fs; end
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int k);
        case (k)
            2: return "R2";
            3: return "R3";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            7: return "R8";
            default: return "R4";
        endcase
    endfunction

    // Compare every port against the model (called between edges).
    task automatic compare();
        bit xr;
        xr = (!e_vld || rec_rdy) && !flush;
        check(retire_rdy == xr, "R9", "retire_rdy", int'(retire_rdy), int'(xr));
        check(rec_vld == e_vld, "R9", "rec_vld", int'(rec_vld), int'(e_vld));
        if (e_vld && rec_vld) begin
            check(int'(rec_slot) == e_slot, "R9", "rec_slot", int'(rec_slot), e_slot);
            check(int'(rec_f_type) == e_fk && int'(rec_f_prod) == e_fp, req_of(e_fk), "F edge",
                  int'({rec_f_type, rec_f_prod}), e_fk * 64 + e_fp);
            check(int'(rec_e_type) == e_ek && int'(rec_e_prod) == e_ep, req_of(e_ek), "E edge",
                  int'({rec_e_type, rec_e_prod}), e_ek * 64 + e_ep);
            check(int'(rec_c_type) == e_ck && int'(rec_c_prod) == e_cp,
                  (e_ck == 6) ? "R7" : "R8", "C edge",
                  int'({rec_c_type, rec_c_prod}), e_ck * 64 + e_cp);
        end
    endtask

    task automatic idle();
        flush = 0; fetch_vld = 0; misp_vld = 0; stall_vld = 0; wake_vld = 0;
        issue_vld = 0; head_vld = 0; retire_vld = 0;
    endtask

    task automatic step();
        @(negedge clk);
        compare();
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rec_vld == 1'b0, "R1", "rec_vld after reset", int'(rec_vld), 0);
        check(retire_rdy == 1'b1, "R1", "retire_rdy after reset", int'(retire_rdy), 1);
        // R10 directed: fetch slot 5, flush, retire slot 5 -> no record
        fetch_vld = 1; fetch_slot = 5; fetch_src_rdy = 2'b11;
        step();
        flush = 1;
        step();
        retire_vld = 1; retire_slot = 5; rec_rdy = 1;
        step();
        step();
        check(rec_vld == 1'b0, "R10", "record for squashed slot", int'(rec_vld), 0);
        // R2 directed: mispredict then fetch, then retire it
        misp_vld = 1; misp_slot = 9; stall_vld = 1;
        step();
        fetch_vld = 1; fetch_slot = 2; fetch_src_rdy = 2'b00; fetch_src_prod = {4'd7, 4'd6};
        step();
        wake_vld = 1; wake_slot = 2; wake_mask = 2'b11;  // R6 tie -> operand 1 (slot 7)
        step();
        retire_vld = 1; retire_slot = 2;
        step();
        step();
        // random phase
        for (int n = 0; n < 6000; n++) begin
            fetch_vld = ($urandom_range(0, 99) < 50);
            fetch_slot = SW'($urandom_range(0, D - 1));
            fetch_src_rdy = NS'($urandom_range(0, 3));
            fetch_src_prod = (NS*SW)'($urandom);
            misp_vld = ($urandom_range(0, 99) < 8);
            misp_slot = SW'($urandom_range(0, D - 1));
            stall_vld = ($urandom_range(0, 99) < 10);
            wake_vld = ($urandom_range(0, 99) < 50);
            wake_slot = SW'($urandom_range(0, D - 1));
            wake_mask = NS'($urandom_range(0, 3));
            issue_vld = ($urandom_range(0, 99) < 40);
            issue_slot = SW'($urandom_range(0, D - 1));
            head_vld = ($urandom_range(0, 99) < 40);
            head_slot = SW'($urandom_range(0, D - 1));
            retire_vld = ($urandom_range(0, 99) < 60);
            retire_slot = SW'($urandom_range(0, D - 1));
            flush = ($urandom_range(0, 199) == 0);
            rec_rdy = ($urandom_range(0, 99) < 70);
            step();
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule